// File: doc/BRIEF.md
# FP8 to Single-Precision Widener

This block widens one 8-bit floating-point operand per cycle to a 32-bit IEEE single-precision word. A one-bit format select picks how the byte is read. In the range-limited layout the byte holds a sign, four exponent bits and three mantissa bits. In the wide-range layout it holds a sign, five exponent bits and two mantissa bits. The result comes out of one register stage, together with a valid flag and four operand-class flags: NaN, infinity, zero and subnormal.

Every operand passes through the same decode. The byte is split into fields, and its class is chosen among five decode states: zero, subnormal, normal, infinity and NaN. A subnormal input goes through a leading-one normaliser. The single-precision word is then put together from the chosen state. The wide-range layout follows the usual IEEE special-value rules. The range-limited layout has no infinity: the codes that would hold infinity are ordinary finite numbers, and only the all-ones pattern is NaN. A capture of the output register is the one transition in the block. It happens on every clock edge where the input strobe is high. When the strobe is low, the register holds its contents.

Top module: `fp8_to_fp32_widener`

## Requirements
- R1: With `fmt_sel`=0 the byte is read as sign[7], exponent[6:3] with bias 7, and mantissa[2:0] with an implicit leading 1. Exponent 1111 with a mantissa other than 111 is a finite normal number, so the largest magnitude is 448 (code 0x7E gives 0x43E00000). This format never raises the infinity flag.
- R2: With `fmt_sel`=0, only the codes 0x7F and 0xFF are NaN. They give the canonical quiet NaN 0x7FC00000 with the input sign placed in bit 31, and they raise the NaN flag.
- R3: With `fmt_sel`=1 the byte is read as sign[7], exponent[6:2] with bias 15, and mantissa[1:0] with an implicit leading 1. Normal values are rebased to bias 127.
- R4: With `fmt_sel`=1, exponent 11111 with mantissa 00 gives a signed infinity (0x7F800000 or 0xFF800000) and raises the infinity flag. Exponent 11111 with a nonzero mantissa gives the signed canonical quiet NaN and raises the NaN flag.
- R5: In either format, a zero exponent with a nonzero mantissa is normalised to an exact single-precision normal number and raises the subnormal flag. For example, 0x01 gives 0x3B000000 in format 0 and 0x37800000 in format 1.
- R6: A zero exponent with a zero mantissa gives a zero that keeps the input sign (0x00000000 or 0x80000000) and raises the zero flag. In every class, bit 31 of the result equals the input sign.
- R7: At most one of the four class flags is high at any time. A normal operand raises none of them.
- R8: `out_vld` equals `in_vld` from one cycle earlier. The result and the flags update only on cycles where `in_vld` is high, and otherwise keep their previous values.
- R9: During reset, and in the cycle after it ends, `out_vld`, the result and all flags are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fmt_sel | input | 1 | 0 = four-bit exponent layout, 1 = five-bit exponent layout |
| in_vld | input | 1 | Input strobe |
| in_code | input | 8 | FP8 operand |
| out_vld | output | 1 | Result valid, one cycle after `in_vld` |
| out_word | output | 32 | Single-precision result |
| out_nan | output | 1 | Operand was NaN |
| out_inf | output | 1 | Operand was infinity |
| out_zero | output | 1 | Operand was a signed zero |
| out_sub | output | 1 | Operand was subnormal |

## Verification
On every cycle, the assertions check the valid latency, the holding of the output register, and the exclusiveness of the flags. They also check that each flag agrees with the special word it comes with, that the sign is carried through, and that the range-limited format never reports infinity. Only the bench's vectors can show the exact numbers produced. These include the rebased exponents, the normalisation of subnormals in both formats, the finite decoding of exponent 1111 up to 448, and the different treatment of the same byte under the two formats.

// File: rtl/fp8w_pkg.sv
package fp8w_pkg;
    localparam int CODE_W    = 8;
    localparam int EXP_W     = 5;
    localparam int MAN_W     = 3;
    localparam int F32_EXP_W = 8;
    localparam int F32_MAN_W = 23;
    localparam int F32_BIAS  = 127;
    localparam int F32_W     = 1 + F32_EXP_W + F32_MAN_W;
    localparam int LEAD_W    = $clog2(MAN_W);

    typedef enum logic {FMT_E4M3 = 1'b0, FMT_E5M2 = 1'b1} fmt_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } cls_e;

    typedef struct packed {
        logic             sgn;
        logic [EXP_W-1:0] exp;
        logic [MAN_W-1:0] man;
    } parts_t;

    typedef struct packed {
        logic nan;
        logic inf;
        logic zero;
        logic sub;
    } flags_t;
endpackage

// File: rtl/fp8w_unpack.sv
module fp8w_unpack
    import fp8w_pkg::*;
#(
    parameter int NARROW_EXP_W = 4,
    parameter int WIDE_EXP_W   = 5
) (
    input  fmt_e                  fmt,
    input  logic [CODE_W-1:0]     code,
    output parts_t                parts,
    output cls_e                  cls,
    output logic [F32_EXP_W-1:0]  bias
);
    localparam int NARROW_MAN_W = CODE_W - 1 - NARROW_EXP_W;
    localparam int WIDE_MAN_W   = CODE_W - 1 - WIDE_EXP_W;
    localparam int NARROW_BIAS  = (1 << (NARROW_EXP_W - 1)) - 1;
    localparam int WIDE_BIAS    = (1 << (WIDE_EXP_W - 1)) - 1;

    logic exp_full;
    logic man_full;

    always_comb begin
        parts.sgn = code[CODE_W-1];
        unique case (fmt)
            FMT_E4M3: begin
                parts.exp = EXP_W'(code[CODE_W-2 -: NARROW_EXP_W]);
                parts.man = MAN_W'(code[NARROW_MAN_W-1:0]) << (MAN_W - NARROW_MAN_W);
                exp_full  = &code[CODE_W-2 -: NARROW_EXP_W];
                man_full  = &code[NARROW_MAN_W-1:0];
                bias      = F32_EXP_W'(NARROW_BIAS);
            end
            FMT_E5M2: begin
                parts.exp = EXP_W'(code[CODE_W-2 -: WIDE_EXP_W]);
                parts.man = MAN_W'(code[WIDE_MAN_W-1:0]) << (MAN_W - WIDE_MAN_W);
                exp_full  = &code[CODE_W-2 -: WIDE_EXP_W];
                man_full  = &code[WIDE_MAN_W-1:0];
                bias      = F32_EXP_W'(WIDE_BIAS);
            end
            default: begin
                parts.exp = '0;
                parts.man = '0;
                exp_full  = 1'b0;
                man_full  = 1'b0;
                bias      = '0;
            end
        endcase
    end

    // Decode state selection: the range-limited layout keeps its top exponent finite
    always_comb begin
        if (parts.exp == '0) begin
            cls = (parts.man == '0) ? CLS_ZERO : CLS_SUB;
        end else if (exp_full) begin
            if (fmt == FMT_E4M3) begin
                cls = man_full ? CLS_NAN : CLS_NORM;
            end else begin
                cls = (parts.man == '0) ? CLS_INF : CLS_NAN;
            end
        end else begin
            cls = CLS_NORM;
        end
    end
endmodule

// File: rtl/fp8w_lead_norm.sv
module fp8w_lead_norm
    import fp8w_pkg::*;
(
    input  logic [MAN_W-1:0]  man,
    output logic [LEAD_W-1:0] lead,
    output logic [MAN_W-1:0]  frac
);
    logic [2*MAN_W-1:0] shifted;

    // Highest set bit wins; the loop runs upward so later hits overwrite earlier ones
    always_comb begin
        lead = '0;
        for (int i = 0; i < MAN_W; i++) begin
            if (man[i]) lead = LEAD_W'(i);
        end
        shifted = {{MAN_W{1'b0}}, man} << (MAN_W - int'(lead));
        frac    = shifted[MAN_W-1:0];
    end
endmodule

// File: rtl/fp8w_pack.sv
module fp8w_pack
    import fp8w_pkg::*;
(
    input  parts_t                parts,
    input  cls_e                  cls,
    input  logic [F32_EXP_W-1:0]  bias,
    input  logic [LEAD_W-1:0]     lead,
    input  logic [MAN_W-1:0]      frac,
    output logic [F32_W-1:0]      word,
    output flags_t                flg
);
    localparam int XW      = F32_EXP_W + 2;
    localparam int PAD_W   = F32_MAN_W - MAN_W;
    localparam int SUB_OFS = F32_BIAS + 1 - MAN_W;

    logic [XW-1:0] e_norm;
    logic [XW-1:0] e_sub;

    always_comb begin
        e_norm = XW'(parts.exp) + XW'(F32_BIAS) - XW'(bias);
        e_sub  = XW'(SUB_OFS) + XW'(lead) - XW'(bias);
        flg    = '0;
        unique case (cls)
            CLS_ZERO: begin
                word     = {parts.sgn, {(F32_W-1){1'b0}}};
                flg.zero = 1'b1;
            end
            CLS_SUB: begin
                word    = {parts.sgn, e_sub[F32_EXP_W-1:0], frac, {PAD_W{1'b0}}};
                flg.sub = 1'b1;
            end
            CLS_NORM: begin
                word = {parts.sgn, e_norm[F32_EXP_W-1:0], parts.man, {PAD_W{1'b0}}};
            end
            CLS_INF: begin
                word    = {parts.sgn, {F32_EXP_W{1'b1}}, {F32_MAN_W{1'b0}}};
                flg.inf = 1'b1;
            end
            CLS_NAN: begin
                word    = {parts.sgn, {F32_EXP_W{1'b1}}, 1'b1, {(F32_MAN_W-1){1'b0}}};
                flg.nan = 1'b1;
            end
            default: begin
                word = '0;
            end
        endcase
    end
endmodule

// File: rtl/fp8_to_fp32_widener.sv
module fp8_to_fp32_widener
    import fp8w_pkg::*;
#(
    parameter int NARROW_EXP_W = 4,
    parameter int WIDE_EXP_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fmt_sel,
    input  logic              in_vld,
    input  logic [CODE_W-1:0] in_code,
    output logic              out_vld,
    output logic [F32_W-1:0]  out_word,
    output logic              out_nan,
    output logic              out_inf,
    output logic              out_zero,
    output logic              out_sub
);
    parts_t                parts;
    cls_e                  cls;
    logic [F32_EXP_W-1:0]  bias;
    logic [LEAD_W-1:0]     lead;
    logic [MAN_W-1:0]      frac;
    logic [F32_W-1:0]      word_c;
    flags_t                flg_c;

    logic [F32_W-1:0]      word_q, word_n;
    flags_t                flg_q, flg_n;
    logic                  vld_q;

    fp8w_unpack #(.NARROW_EXP_W(NARROW_EXP_W), .WIDE_EXP_W(WIDE_EXP_W)) u_unpack (
        .fmt   (fmt_e'(fmt_sel)),
        .code  (in_code),
        .parts (parts),
        .cls   (cls),
        .bias  (bias)
    );

    fp8w_lead_norm u_norm (
        .man  (parts.man),
        .lead (lead),
        .frac (frac)
    );

    fp8w_pack u_pack (
        .parts (parts),
        .cls   (cls),
        .bias  (bias),
        .lead  (lead),
        .frac  (frac),
        .word  (word_c),
        .flg   (flg_c)
    );

    // Next-value selection: capture on strobe, otherwise hold
    always_comb begin
        word_n = in_vld ? word_c : word_q;
        flg_n  = in_vld ? flg_c  : flg_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vld_q  <= 1'b0;
            word_q <= '0;
            flg_q  <= '0;
        end else begin
            vld_q  <= in_vld;
            word_q <= word_n;
            flg_q  <= flg_n;
        end
    end

    always_comb begin
        out_vld  = vld_q;
        out_word = word_q;
        out_nan  = flg_q.nan;
        out_inf  = flg_q.inf;
        out_zero = flg_q.zero;
        out_sub  = flg_q.sub;
    end

    assert_valid_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);
    assert_valid_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);
    assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> ($stable(out_word) && $stable({out_nan, out_inf, out_zero, out_sub})));
    assert_flag_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({out_nan, out_inf, out_zero, out_sub}));
    assert_nan_canon_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_nan |-> (out_word[F32_W-2:0] == 31'h7FC00000));
    assert_inf_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_inf |-> (out_word[F32_W-2:0] == 31'h7F800000));
    assert_zero_word_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_zero |-> (out_word[F32_W-2:0] == '0));
    assert_sign_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> (out_word[F32_W-1] == $past(in_code[CODE_W-1])));
    assert_narrow_noinf_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && !fmt_sel) |=> !out_inf);
endmodule

// File: tb/fp8_to_fp32_widener_test.sv
module fp8_to_fp32_widener_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fmt_sel = 1'b0;
    logic        in_vld = 1'b0;
    logic [7:0]  in_code = 8'h00;
    logic        out_vld;
    logic [31:0] out_word;
    logic        out_nan, out_inf, out_zero, out_sub;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fp8_to_fp32_widener uut (
        .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .in_vld(in_vld), .in_code(in_code),
        .out_vld(out_vld), .out_word(out_word), .out_nan(out_nan), .out_inf(out_inf),
        .out_zero(out_zero), .out_sub(out_sub)
    );

    // {fmt, code, expected word, flags {nan,inf,zero,sub}}
    localparam int NV = 27;
    localparam logic [44:0] VEC [NV] = '{
        {1'b0, 8'h00, 32'h00000000, 4'b0010},
        {1'b0, 8'h80, 32'h80000000, 4'b0010},
        {1'b0, 8'h38, 32'h3F800000, 4'b0000},
        {1'b0, 8'h7E, 32'h43E00000, 4'b0000},
        {1'b0, 8'hFE, 32'hC3E00000, 4'b0000},
        {1'b0, 8'h78, 32'h43800000, 4'b0000},
        {1'b0, 8'h7C, 32'h43C00000, 4'b0000},
        {1'b0, 8'h7F, 32'h7FC00000, 4'b1000},
        {1'b0, 8'hFF, 32'hFFC00000, 4'b1000},
        {1'b0, 8'h01, 32'h3B000000, 4'b0001},
        {1'b0, 8'h07, 32'h3C600000, 4'b0001},
        {1'b0, 8'h86, 32'hBC400000, 4'b0001},
        {1'b0, 8'h08, 32'h3C800000, 4'b0000},
        {1'b0, 8'hC4, 32'hC0400000, 4'b0000},
        {1'b1, 8'h3C, 32'h3F800000, 4'b0000},
        {1'b1, 8'h7C, 32'h7F800000, 4'b0100},
        {1'b1, 8'hFC, 32'hFF800000, 4'b0100},
        {1'b1, 8'h7D, 32'h7FC00000, 4'b1000},
        {1'b1, 8'hFF, 32'hFFC00000, 4'b1000},
        {1'b1, 8'h7E, 32'h7FC00000, 4'b1000},
        {1'b1, 8'h7B, 32'h47600000, 4'b0000},
        {1'b1, 8'h78, 32'h47000000, 4'b0000},
        {1'b1, 8'h01, 32'h37800000, 4'b0001},
        {1'b1, 8'h03, 32'h38400000, 4'b0001},
        {1'b1, 8'h04, 32'h38800000, 4'b0000},
        {1'b1, 8'h80, 32'h80000000, 4'b0010},
        {1'b1, 8'h00, 32'h00000000, 4'b0010}
    };

    function automatic string req_of(input logic f, input logic [3:0] fl);
        if (fl[3]) return f ? "R4" : "R2";
        if (fl[2]) return "R4";
        if (fl[1]) return "R6";
        if (fl[0]) return "R5";
        return f ? "R3" : "R1";
    endfunction

    task automatic check(input string req, input logic [36:0] act, input logic [36:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got vld=%0b word=%08h flags=%04b, expected vld=%0b word=%08h flags=%04b",
                     req, act[36], act[35:4], act[3:0], exp[36], exp[35:4], exp[3:0]);
        end
    endtask

    function automatic logic [36:0] seen();
        return {out_vld, out_word, out_nan, out_inf, out_zero, out_sub};
    endfunction

    task automatic finish_run();
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #2_000_000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got running, expected finished");
        finish_run();
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9", seen(), 37'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", seen(), 37'h0);

        // Table walk: drive on falling edge, sample one cycle later
        for (int i = 0; i < NV; i++) begin
            fmt_sel = VEC[i][44];
            in_code = VEC[i][43:36];
            in_vld  = 1'b1;
            @(negedge clk);
            check(req_of(VEC[i][44], VEC[i][3:0]), seen(), {1'b1, VEC[i][35:0]});
        end

        // R8: strobe low holds the last result, valid drops
        fmt_sel = 1'b0; in_code = 8'h38; in_vld = 1'b1;
        @(negedge clk);
        check("R8", seen(), {1'b1, 32'h3F800000, 4'b0000});
        fmt_sel = 1'b1; in_code = 8'h7C; in_vld = 1'b0;
        @(negedge clk);
        check("R8", seen(), {1'b0, 32'h3F800000, 4'b0000});
        @(negedge clk);
        check("R8", seen(), {1'b0, 32'h3F800000, 4'b0000});

        // R8: one-cycle latency when strobe returns; R7 flags exclusive
        in_vld = 1'b1; fmt_sel = 1'b1; in_code = 8'h7C;
        @(negedge clk);
        check("R8", seen(), {1'b1, 32'h7F800000, 4'b0100});
        fmt_sel = 1'b0;
        @(negedge clk);
        check("R7", seen(), {1'b1, 32'h43C00000, 4'b0000});

        // R1: same byte under the two formats, back to back
        in_code = 8'h78; fmt_sel = 1'b0;
        @(negedge clk);
        check("R1", seen(), {1'b1, 32'h43800000, 4'b0000});
        fmt_sel = 1'b1;
        @(negedge clk);
        check("R3", seen(), {1'b1, 32'h47000000, 4'b0000});
        in_vld = 1'b0;

        // R9: reset asserted mid-run clears everything
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9", seen(), 37'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9", seen(), 37'h0);

        finish_run();
    end
endmodule